// File: doc/BRIEF.md
# Nibble-Streaming Sample Playback Sequencer

This block plays one-shot samples stored in an external byte-wide ROM. Each sample is a run of 4-bit compressed codes, packed two to a byte. A host writes three registers: an end page, a start page and a volume code. Writing the start page both loads the page and requests playback. The block divides its base clock into a sample strobe. It then walks the ROM one byte every two sample periods and hands the downstream decoder one nibble per sample period, the high nibble first.

A sample always begins at offset 0 of its start page. It stops when the page counter reaches the end page, so every sample occupies whole pages. The decoder reset output is held while the player is idle. Every start request also drives that reset for a fixed number of full sample periods before new codes flow, even if a sample is already playing. The decoder therefore never sees a torn sequence. The volume code is cleared only by a start write, so a volume written during the reset window survives.

Top module: `smp_player`

## Requirements
- R1: `smp_strobe` is high for one clock in every DIV clocks; the first pulse comes DIV clocks after reset is released.
- R2: On each streaming strobe, `dec_nib` takes the next nibble of the current ROM byte: bits 7:4 first, then bits 3:0. It does not change between strobes.
- R3: `rom_addr` is {page, byte}. The byte offset advances after the second nibble of a byte. When the offset wraps, the page counter increments, modulo the page count.
- R4: A write with `wr_sel`=1 loads the page counter from the low PAGE_W bits of `wr_data` and raises a pending request. At the next strobe the request is taken: offset 0, high nibble next, and `playing`=1.
- R5: A write with `wr_sel`=0 stores all 8 bits of `wr_data` as the end page. A streaming strobe that finds the zero-extended page equal to it clears `playing` without presenting a nibble. A start equal to the end presents no nibble.
- R6: `dec_rst` is high while `playing` is 0, while a request is pending, and for HOLD full sample periods after a request is taken.
- R7: A start write during playback is honoured and restarts the reset window and the page.
- R8: A write with `wr_sel`=2 sets `vol` to `wr_data[3:0]`. A start write clears `vol` to 0. The reset window leaves `vol` unchanged.
- R9: A write with `wr_sel`=3 changes no output.
- R10: After reset, `rom_addr`=0, `dec_nib`=0, `vol`=0, `playing`=0 and `dec_rst`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 end page, 1 start page, 2 volume, 3 none |
| wr_data | input | 8 | Write data |
| rom_data | input | 8 | Byte read from the sample ROM |
| rom_addr | output | PAGE_W+BYTE_W | ROM address {page, byte offset} |
| smp_strobe | output | 1 | One-clock sample period strobe |
| dec_nib | output | 4 | Nibble presented to the decoder |
| dec_rst | output | 1 | Decoder reset |
| playing | output | 1 | Play/stop state |
| vol | output | 4 | Volume code |

## Verification
The bench builds the block with DIV=4, HOLD=4, BYTE_W=3 and PAGE_W=3, so a page is eight bytes and there are eight pages. With these values a full page streams in 64 clocks. The page counter wrap from 7 to 0, the end compare, an empty sample, a restart inside a running sample and back-to-back start writes all happen within a few hundred clocks. The default HOLD keeps the reset window at its real length in sample periods.

// File: rtl/smp_pkg.sv
package smp_pkg;
   typedef enum logic [1:0] {
      SEL_END   = 2'd0,
      SEL_START = 2'd1,
      SEL_VOL   = 2'd2,
      SEL_NONE  = 2'd3
   } reg_sel_t;
endpackage

// File: rtl/smp_prescaler.sv
module smp_prescaler #(
   parameter int DIV = 64
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   if (DIV < 2) begin : g_bad_div
      $error("smp_prescaler: DIV must be at least 2");
   end

   logic [CW-1:0] cnt;

   assign tick = (cnt == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= '0;
      else           cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/smp_restart_ctl.sv
module smp_restart_ctl #(
   parameter int HOLD = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic start_wr,
   input  logic at_end,
   output logic take,
   output logic go,
   output logic playing,
   output logic dec_rst
);
   localparam int HW = $clog2(HOLD + 1);
   localparam logic [HW-1:0] HFULL = HW'(HOLD);
   localparam logic [HW-1:0] HGO   = HW'(HOLD - 1);

   if (HOLD < 1) begin : g_bad_hold
      $error("smp_restart_ctl: HOLD must be at least 1");
   end

   logic          req;
   logic          play;
   logic [HW-1:0] hold;
   logic          ready;
   logic          stop;

   assign take  = tick && req;
   assign ready = tick && !req && play && (hold >= HGO);
   assign go    = ready && !at_end;
   assign stop  = ready && at_end;

   always_ff @(posedge clk) begin
      if (!rst_n)        req <= 1'b0;
      else if (start_wr) req <= 1'b1;
      else if (take)     req <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    play <= 1'b0;
      else if (take) play <= 1'b1;
      else if (stop) play <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                     hold <= HFULL;
      else if (take)                  hold <= '0;
      else if (tick && hold < HFULL)  hold <= hold + 1'b1;
   end

   assign playing = play;
   assign dec_rst = !play || req || (hold < HFULL);
endmodule

// File: rtl/smp_addr_gen.sv
module smp_addr_gen #(
   parameter int BYTE_W     = 8,
   parameter int PAGE_W     = 7,
   parameter int NIB_W      = 4,
   parameter int REG_W      = 8,
   parameter bit HIGH_FIRST = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load,
   input  logic [PAGE_W-1:0]        load_page,
   input  logic [REG_W-1:0]         end_page,
   input  logic                     take,
   input  logic                     go,
   input  logic [2*NIB_W-1:0]       rom_data,
   output logic [PAGE_W+BYTE_W-1:0] rom_addr,
   output logic [NIB_W-1:0]         dec_nib,
   output logic                     at_end
);
   localparam logic [BYTE_W-1:0] BYTE_LAST = '1;

   logic [PAGE_W-1:0] page;
   logic [BYTE_W-1:0] offs;
   logic              nib_sel;
   logic [NIB_W-1:0]  first_nib;
   logic [NIB_W-1:0]  second_nib;

   if (HIGH_FIRST) begin : g_high_first
      assign first_nib  = rom_data[2*NIB_W-1:NIB_W];
      assign second_nib = rom_data[NIB_W-1:0];
   end else begin : g_low_first
      assign first_nib  = rom_data[NIB_W-1:0];
      assign second_nib = rom_data[2*NIB_W-1:NIB_W];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                                page <= '0;
      else if (load)                             page <= load_page;
      else if (go && nib_sel && offs == BYTE_LAST) page <= page + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)               offs <= '0;
      else if (take)            offs <= '0;
      else if (go && nib_sel)   offs <= offs + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     nib_sel <= 1'b0;
      else if (take)  nib_sel <= 1'b0;
      else if (go)    nib_sel <= ~nib_sel;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)   dec_nib <= '0;
      else if (go)  dec_nib <= nib_sel ? second_nib : first_nib;
   end

   assign rom_addr = {page, offs};
   assign at_end   = (end_page == REG_W'(page));
endmodule

// File: rtl/smp_player.sv
module smp_player
   import smp_pkg::*;
#(
   parameter int DIV        = 64,
   parameter int HOLD       = 4,
   parameter int BYTE_W     = 8,
   parameter int PAGE_W     = 7,
   parameter int NIB_W      = 4,
   parameter int VOL_W      = 4,
   parameter int REG_W      = 8,
   parameter bit HIGH_FIRST = 1'b1,
   localparam int ADDR_W    = PAGE_W + BYTE_W,
   localparam int DATA_W    = 2 * NIB_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [REG_W-1:0]  wr_data,
   input  logic [DATA_W-1:0] rom_data,
   output logic [ADDR_W-1:0] rom_addr,
   output logic              smp_strobe,
   output logic [NIB_W-1:0]  dec_nib,
   output logic              dec_rst,
   output logic              playing,
   output logic [VOL_W-1:0]  vol
);
   if (PAGE_W > REG_W || VOL_W > REG_W) begin : g_bad_widths
      $error("smp_player: PAGE_W and VOL_W must fit in REG_W");
   end

   reg_sel_t         sel;
   logic             start_wr;
   logic             end_wr;
   logic             vol_wr;
   logic [REG_W-1:0] end_q;
   logic             tick;
   logic             take;
   logic             go;
   logic             at_end;

   assign sel      = reg_sel_t'(wr_sel);
   assign start_wr = wr_en && (sel == SEL_START);
   assign end_wr   = wr_en && (sel == SEL_END);
   assign vol_wr   = wr_en && (sel == SEL_VOL);

   always_ff @(posedge clk) begin
      if (!rst_n)      end_q <= '0;
      else if (end_wr) end_q <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        vol <= '0;
      else if (start_wr) vol <= '0;
      else if (vol_wr)   vol <= wr_data[VOL_W-1:0];
   end

   smp_prescaler #(.DIV(DIV)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   smp_restart_ctl #(.HOLD(HOLD)) u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .start_wr (start_wr),
      .at_end   (at_end),
      .take     (take),
      .go       (go),
      .playing  (playing),
      .dec_rst  (dec_rst)
   );

   smp_addr_gen #(
      .BYTE_W     (BYTE_W),
      .PAGE_W     (PAGE_W),
      .NIB_W      (NIB_W),
      .REG_W      (REG_W),
      .HIGH_FIRST (HIGH_FIRST)
   ) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (start_wr),
      .load_page (wr_data[PAGE_W-1:0]),
      .end_page  (end_q),
      .take      (take),
      .go        (go),
      .rom_data  (rom_data),
      .rom_addr  (rom_addr),
      .dec_nib   (dec_nib),
      .at_end    (at_end)
   );

   assign smp_strobe = tick;
endmodule

// File: rtl/smp_player_chk.sv
module smp_player_chk
   import smp_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int ADDR_W = 15,
   parameter int NIB_W  = 4,
   parameter int VOL_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [1:0]        wr_sel,
   input logic [ADDR_W-1:0] rom_addr,
   input logic              smp_strobe,
   input logic [NIB_W-1:0]  dec_nib,
   input logic              dec_rst,
   input logic              playing,
   input logic [VOL_W-1:0]  vol
);
   logic start_w;
   assign start_w = wr_en && (wr_sel == SEL_START);

   p_strobe_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      smp_strobe |=> !smp_strobe);

   p_nib_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_strobe |=> $stable(dec_nib));

   p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!smp_strobe && !start_w) |=> $stable(rom_addr));

   p_first_offset_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(playing) |-> (rom_addr[BYTE_W-1:0] == '0));

   p_stop_on_page_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(playing) |-> (rom_addr[BYTE_W-1:0] == '0));

   p_idle_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !playing |-> dec_rst);

   p_restart_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
      start_w |=> dec_rst);

   p_vol_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      start_w |=> (vol == '0));
endmodule

bind smp_player smp_player_chk #(
   .BYTE_W (BYTE_W),
   .ADDR_W (ADDR_W),
   .NIB_W  (NIB_W),
   .VOL_W  (VOL_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_sel     (wr_sel),
   .rom_addr   (rom_addr),
   .smp_strobe (smp_strobe),
   .dec_nib    (dec_nib),
   .dec_rst    (dec_rst),
   .playing    (playing),
   .vol        (vol)
);

// File: tb/tb_smp_player.sv
module tb_smp_player;
   localparam int DIV    = 4;
   localparam int HOLD   = 4;
   localparam int BYTE_W = 3;
   localparam int PAGE_W = 3;
   localparam int ADDR_W = BYTE_W + PAGE_W;
   localparam int BYTES  = 1 << BYTE_W;
   localparam int PAGES  = 1 << PAGE_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [1:0]        wr_sel = 2'd3;
   logic [7:0]        wr_data = 8'd0;
   logic [7:0]        rom_data;
   logic [ADDR_W-1:0] rom_addr;
   logic              smp_strobe;
   logic [3:0]        dec_nib;
   logic              dec_rst;
   logic              playing;
   logic [3:0]        vol;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   bit cmp_on = 1'b0;

   // model state
   int m_cnt = 0, m_page = 0, m_end = 0, m_vol = 0, m_req = 0, m_play = 0;
   int m_hold = HOLD, m_byte = 0, m_nib = 0, m_out = 0, m_d = 0;
   bit m_tk = 1'b0;

   always #5 clk = ~clk;

   function automatic int romf(int a);
      return ((a * 29) ^ 8'h5A) & 8'hFF;
   endfunction

   assign rom_data = 8'(romf(int'(rom_addr)));

   smp_player #(
      .DIV(DIV), .HOLD(HOLD), .BYTE_W(BYTE_W), .PAGE_W(PAGE_W)
   ) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .rom_data(rom_data), .rom_addr(rom_addr),
      .smp_strobe(smp_strobe), .dec_nib(dec_nib), .dec_rst(dec_rst),
      .playing(playing), .vol(vol)
   );

   task automatic chk(string tag, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   // behavioural reference, advanced on every rising edge
   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_cnt = 0; m_page = 0; m_end = 0; m_vol = 0; m_req = 0;
         m_play = 0; m_hold = HOLD; m_byte = 0; m_nib = 0; m_out = 0;
      end else begin
         m_tk = (m_cnt == DIV - 1);
         m_cnt = m_tk ? 0 : m_cnt + 1;
         if (m_tk) begin
            if (m_req != 0) begin
               m_req = 0; m_play = 1; m_hold = 0; m_byte = 0; m_nib = 0;
            end else begin
               if (m_play != 0 && m_hold >= HOLD - 1) begin
                  if (m_page == m_end) m_play = 0;
                  else begin
                     m_d = romf(m_page * BYTES + m_byte);
                     m_out = (m_nib != 0) ? (m_d & 15) : (m_d >> 4);
                     if (m_nib != 0) begin
                        m_nib = 0;
                        if (m_byte == BYTES - 1) begin
                           m_byte = 0;
                           m_page = (m_page + 1) % PAGES;
                        end else m_byte++;
                     end else m_nib = 1;
                  end
               end
               if (m_hold < HOLD) m_hold++;
            end
         end
         if (wr_en) begin
            case (wr_sel)
               2'd0: m_end = wr_data;
               2'd1: begin m_page = wr_data % PAGES; m_req = 1; m_vol = 0; end
               2'd2: m_vol = wr_data & 15;
               default: ;
            endcase
         end
      end
      if (cyc > 20000) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   // per-clock comparison away from the active edge
   always @(negedge clk) begin
      if (cmp_on) begin
         chk("R1 smp_strobe", int'(smp_strobe), int'(m_cnt == DIV - 1));
         chk("R3 rom_addr", int'(rom_addr), m_page * BYTES + m_byte);
         chk("R2 dec_nib", int'(dec_nib), m_out);
         chk("R6 dec_rst", int'(dec_rst),
             int'(m_play == 0 || m_req != 0 || m_hold < HOLD));
         chk("R5 playing", int'(playing), m_play);
         chk("R8 vol", int'(vol), m_vol);
      end
   end

   task automatic wr(int sel, int data);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = 2'(sel); wr_data = 8'(data);
      @(negedge clk);
      wr_en = 1'b0; wr_sel = 2'd3;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      idle(3);
      // R10: reset state
      chk("R10 rom_addr", int'(rom_addr), 0);
      chk("R10 dec_nib", int'(dec_nib), 0);
      chk("R10 vol", int'(vol), 0);
      chk("R10 playing", int'(playing), 0);
      chk("R10 dec_rst", int'(dec_rst), 1);
      rst_n = 1'b1;
      cmp_on = 1'b1;
      idle(10);

      // R4/R5: plain sample over pages 1..2
      wr(0, 3); wr(1, 1); wr(2, 9);
      idle(200);
      chk("R5 stopped after end page", int'(playing), 0);

      // R7: restart while playing, R8: volume during reset window
      wr(0, 6); wr(1, 4); wr(2, 5);
      idle(40);
      wr(1, 5);
      chk("R8 vol cleared by start", int'(vol), 0);
      idle(3);
      wr(2, 7);
      idle(30);
      chk("R8 vol kept over reset window", int'(vol), 7);
      chk("R7 restarted page", int'(rom_addr) / BYTES, 5);
      chk("R7 streaming after restart", int'(dec_rst), 0);
      idle(100);

      // R5: empty sample
      wr(0, 2); wr(1, 2);
      idle(40);
      chk("R5 empty sample idle", int'(playing), 0);
      chk("R5 empty sample reset", int'(dec_rst), 1);

      // R9: unused select
      wr(2, 11);
      wr(3, 8'hA5);
      idle(2);
      chk("R9 vol unchanged", int'(vol), 11);
      chk("R9 still idle", int'(playing), 0);

      // R3: page counter wrap 7 -> 0, end page 1
      wr(0, 1); wr(1, 7);
      idle(180);

      // R4: back-to-back start writes, then end page unreachable
      wr(0, 8'h80); wr(1, 3); wr(1, 6);
      idle(120);
      wr(0, 0); wr(1, 6);
      idle(200);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule